// File: doc/BRIEF.md
# Host-to-Processor Halfword Port Bridge

This block sits between a 32-bit host slave interface and the 16-bit host port of a processor node. The host sees three 32-bit registers, selected by a two-bit code: an address register, a control register and a data register. Address writes and data reads or writes are carried to the node as two 16-bit port transfers, each completed by its own ready handshake. The host acknowledge comes only after both halves are done.

The control register is kept inside the bridge. Its bit 0 picks which halfword travels first, and its bit 1 is a host-interrupt flag that is driven straight onto a status output. Port traffic is locked out until the host has written the control register once with bit 0 set. After that, the lock stays open until reset. A host driver therefore writes the control register once, loads the target address, and then moves data one 32-bit word at a time.

Top module: `hpb_bridge`

## Requirements
- R1: After reset, h_ack_o, p_req_o and hint_o are 0, and a control register read returns 0.
- R2: The control register (h_sel_i=1) holds bit 0 (order) and bit 1 (hint). All other bits read as 0. Control accesses cause no port activity and are acknowledged in the first cycle after the request is accepted.
- R3: Until the first control write with bit 0 set, a port-bound access (address write, data read or data write) is acknowledged without any port activity. A read returns 0 and the address register keeps its value.
- R4: Once enabled, port access stays enabled until reset, even if the order bit is later written to 0.
- R5: With order=1 the first halfword carries data bits 15:0 and the second carries bits 31:16. With order=0 the first carries bits 31:16. This holds for write data and for assembling read data.
- R6: p_half_o is 0 during the first transfer of an access and 1 during the second.
- R7: Each port transfer holds p_half_o and p_wdata_o steady until p_rdy_i. h_ack_o is a one-cycle pulse that follows only after two ready handshakes.
- R8: An address write (h_sel_i=0) is sent with p_reg_o=0 and updates the address register. An address read returns the stored value without port activity.
- R9: A data access (h_sel_i=2) is sent with p_reg_o=1 and p_we_o equal to the host write flag.
- R10: hint_o always equals control bit 1 and changes only on a control write.
- R11: Select code 3 is acknowledged, reads return 0, writes have no effect, and no port activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| h_req_i | input | 1 | Host request, held until h_ack_o |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_sel_i | input | 2 | Register select: 0 address, 1 control, 2 data, 3 reserved |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data, valid with h_ack_o |
| h_ack_o | output | 1 | One-cycle completion pulse |
| p_req_o | output | 1 | Port transfer request |
| p_we_o | output | 1 | Port transfer direction, 1 is write |
| p_reg_o | output | 1 | Port register: 0 address, 1 data |
| p_half_o | output | 1 | Half select: 0 first halfword, 1 second |
| p_wdata_o | output | 16 | Port write halfword |
| p_rdata_i | input | 16 | Port read halfword |
| p_rdy_i | input | 1 | Port transfer ready |
| hint_o | output | 1 | Host-interrupt status, mirror of control bit 1 |

## Verification
Four properties are checked on every cycle:
- a transfer holds its half select and data until ready;
- the acknowledge is a single pulse that follows exactly zero or two ready handshakes;
- no port request appears before the enable is set, and the enable never drops once set;
- the status bit moves only after a control write.

Which halfword goes first, the assembled read word, the register code and direction on the port, and the lock-out values can only be shown by the bench. It sweeps both orders, three ready delays and each port-bound operation, and compares every logged transfer with values it computes itself.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_RSVD = 2'd3
  } hsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_H0   = 2'd1,
    ST_H1   = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  localparam int unsigned CTRL_ORDER_BIT = 0;
  localparam int unsigned CTRL_HINT_BIT  = 1;
endpackage

// File: rtl/hpb_regs.sv
module hpb_regs
  import hpb_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          order_o,
  output logic          hint_o,
  output logic          armed_o,
  output logic [DW-1:0] ctrl_rd_o,
  output logic [DW-1:0] addr_rd_o
);
  logic          order_q, hint_q, armed_q;
  logic [DW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q <= 1'b0;
      hint_q  <= 1'b0;
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (wr_ctrl_i) begin
        order_q <= wdata_i[CTRL_ORDER_BIT];
        hint_q  <= wdata_i[CTRL_HINT_BIT];
        if (wdata_i[CTRL_ORDER_BIT]) armed_q <= 1'b1;  // sticky until reset
      end
      if (wr_addr_i) addr_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_ORDER_BIT] = order_q;
    ctrl_rd_o[CTRL_HINT_BIT]  = hint_q;
  end

  assign order_o   = order_q;
  assign hint_o    = hint_q;
  assign armed_o   = armed_q;
  assign addr_rd_o = addr_q;

  a_r4_armed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
endmodule

// File: rtl/hpb_seq.sv
module hpb_seq
  import hpb_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [1:0]    h_sel_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  output logic          h_ack_o,
  input  logic          armed_i,
  input  logic          order_i,
  input  logic [DW-1:0] ctrl_rd_i,
  input  logic [DW-1:0] addr_rd_i,
  output logic          wr_ctrl_o,
  output logic          wr_addr_o,
  output logic          p_req_o,
  output logic          p_we_o,
  output logic          p_reg_o,
  output logic          p_half_o,
  output logic [HW-1:0] p_wdata_o,
  input  logic [HW-1:0] p_rdata_i,
  input  logic          p_rdy_i
);
  st_e           st_q, st_d;
  hsel_e         sel_in, sel_q;
  logic          we_q, ord_q;
  logic [DW-1:0] wd_q, rd_q, rd_local;
  logic          accept, to_port, go_port, pos, xfer_done;

  assign sel_in  = hsel_e'(h_sel_i);
  assign accept  = (st_q == ST_IDLE) && h_req_i;
  assign to_port = (sel_in == SEL_DATA) || ((sel_in == SEL_ADDR) && h_we_i);
  assign go_port = accept && to_port && armed_i;

  assign wr_ctrl_o = accept && h_we_i && (sel_in == SEL_CTRL);
  assign wr_addr_o = go_port && (sel_in == SEL_ADDR);

  always_comb begin
    rd_local = '0;
    if (!h_we_i && sel_in == SEL_CTRL) rd_local = ctrl_rd_i;
    if (!h_we_i && sel_in == SEL_ADDR) rd_local = addr_rd_i;
  end

  // pos selects the data half on the wire: 0 is bits HW-1:0
  assign p_req_o   = (st_q == ST_H0) || (st_q == ST_H1);
  assign p_half_o  = (st_q == ST_H1);
  assign pos       = ord_q ? p_half_o : ~p_half_o;
  assign p_wdata_o = pos ? wd_q[DW-1:HW] : wd_q[HW-1:0];
  assign p_we_o    = we_q;
  assign p_reg_o   = (sel_q == SEL_DATA);
  assign xfer_done = p_req_o && p_rdy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (h_req_i) st_d = go_port ? ST_H0 : ST_DONE;
      ST_H0:   if (p_rdy_i) st_d = ST_H1;
      ST_H1:   if (p_rdy_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= SEL_ADDR;
      we_q  <= 1'b0;
      ord_q <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        sel_q <= sel_in;
        we_q  <= h_we_i;
        ord_q <= order_i;
        wd_q  <= h_wdata_i;
        rd_q  <= rd_local;
      end else if (xfer_done && !we_q) begin
        if (pos) rd_q[DW-1:HW] <= p_rdata_i;
        else     rd_q[HW-1:0]  <= p_rdata_i;
      end
    end
  end

  assign h_ack_o   = (st_q == ST_DONE);
  assign h_rdata_o = rd_q;

  a_r7_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_req_o && !p_rdy_i) |=> (p_req_o && $stable(p_half_o) && $stable(p_wdata_o)));
  a_r7_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ack_o |=> !h_ack_o);
  a_r3_no_port_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o |-> armed_i);
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
  import hpb_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [1:0]    h_sel_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  output logic          h_ack_o,
  output logic          p_req_o,
  output logic          p_we_o,
  output logic          p_reg_o,
  output logic          p_half_o,
  output logic [HW-1:0] p_wdata_o,
  input  logic [HW-1:0] p_rdata_i,
  input  logic          p_rdy_i,
  output logic          hint_o
);
  logic          wr_ctrl, wr_addr, order, armed;
  logic [DW-1:0] ctrl_rd, addr_rd;

  hpb_regs #(.HW(HW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wr_addr_i (wr_addr),
    .wdata_i   (h_wdata_i),
    .order_o   (order),
    .hint_o    (hint_o),
    .armed_o   (armed),
    .ctrl_rd_o (ctrl_rd),
    .addr_rd_o (addr_rd)
  );

  hpb_seq #(.HW(HW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_req_i   (h_req_i),
    .h_we_i    (h_we_i),
    .h_sel_i   (h_sel_i),
    .h_wdata_i (h_wdata_i),
    .h_rdata_o (h_rdata_o),
    .h_ack_o   (h_ack_o),
    .armed_i   (armed),
    .order_i   (order),
    .ctrl_rd_i (ctrl_rd),
    .addr_rd_i (addr_rd),
    .wr_ctrl_o (wr_ctrl),
    .wr_addr_o (wr_addr),
    .p_req_o   (p_req_o),
    .p_we_o    (p_we_o),
    .p_reg_o   (p_reg_o),
    .p_half_o  (p_half_o),
    .p_wdata_o (p_wdata_o),
    .p_rdata_i (p_rdata_i),
    .p_rdy_i   (p_rdy_i)
  );

  // ready handshakes seen since the last acknowledge
  logic [1:0] rdy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdy_cnt_q <= '0;
    else if (h_ack_o)             rdy_cnt_q <= '0;
    else if (p_req_o && p_rdy_i)  rdy_cnt_q <= rdy_cnt_q + 2'd1;
  end

  a_r7_two_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ack_o |-> (rdy_cnt_q == 2'd0 || rdy_cnt_q == 2'd2));
  a_r7_ready_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_req_o && p_rdy_i) |-> (rdy_cnt_q < 2'd2));
  a_r10_hint_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hint_o) |-> $past(wr_ctrl));
endmodule

// File: tb/hpb_bridge_tb.sv
module hpb_bridge_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        h_req_i = 1'b0, h_we_i = 1'b0;
  logic [1:0]  h_sel_i = 2'd0;
  logic [31:0] h_wdata_i = '0;
  logic [31:0] h_rdata_o;
  logic        h_ack_o, p_req_o, p_we_o, p_reg_o, p_half_o, hint_o;
  logic [15:0] p_wdata_o;
  logic [15:0] p_rdata_i = '0;
  logic        p_rdy_i = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  hpb_bridge u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_req_i(h_req_i), .h_we_i(h_we_i),
    .h_sel_i(h_sel_i), .h_wdata_i(h_wdata_i), .h_rdata_o(h_rdata_o),
    .h_ack_o(h_ack_o), .p_req_o(p_req_o), .p_we_o(p_we_o), .p_reg_o(p_reg_o),
    .p_half_o(p_half_o), .p_wdata_o(p_wdata_o), .p_rdata_i(p_rdata_i),
    .p_rdy_i(p_rdy_i), .hint_o(hint_o)
  );

  // port responder and transfer log
  int          wait_n = 0, wcnt = 0, lg_n = 0, port_cycles = 0;
  logic [15:0] rd_pat [2];
  logic        lg_we [8], lg_reg [8], lg_half [8];
  logic [15:0] lg_data [8];

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_rdy_i = 1'b0; wcnt = 0;
    end else begin
      if (p_req_o) port_cycles++;
      if (p_rdy_i) p_rdy_i = 1'b0;
      else if (p_req_o) begin
        if (wcnt >= wait_n) begin
          p_rdy_i   = 1'b1;
          p_rdata_i = rd_pat[p_half_o];
          if (lg_n < 8) begin
            lg_we[lg_n] = p_we_o; lg_reg[lg_n] = p_reg_o;
            lg_half[lg_n] = p_half_o; lg_data[lg_n] = p_wdata_o;
          end
          lg_n++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk_i);
    lg_n = 0;
    h_req_i = 1'b1; h_we_i = we; h_sel_i = sel; h_wdata_i = wd; cyc = 0;
    do begin @(negedge clk_i); cyc++; end while (!h_ack_o && cyc < 200);
    rd = h_rdata_o;
    h_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_rd;
    int cyc, pc;
    logic [15:0] first, second;
    rd_pat[0] = 16'h0000; rd_pat[1] = 16'h0000;
    repeat (3) @(negedge clk_i);
    chk(h_ack_o == 0 && p_req_o == 0 && hint_o == 0, "R1 reset outputs",
        {29'd0, h_ack_o, p_req_o, hint_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    host(0, 2'd1, 0, rd, cyc);
    chk(rd == 0, "R1 control after reset", rd, 0);

    // locked: port-bound accesses make no port activity
    pc = port_cycles;
    host(1, 2'd2, 32'hDEAD_BEEF, rd, cyc);
    chk(port_cycles == pc, "R3 data write locked", port_cycles, pc);
    host(0, 2'd2, 0, rd, cyc);
    chk(rd == 0 && port_cycles == pc, "R3 data read locked returns 0", rd, 0);
    host(1, 2'd0, 32'h1357_9BDF, rd, cyc);
    host(0, 2'd0, 0, rd, cyc);
    chk(rd == 0 && port_cycles == pc, "R3 address unchanged while locked", rd, 0);
    host(1, 2'd1, 32'h0000_0002, rd, cyc);
    chk(cyc == 1, "R2 control ack latency", cyc, 1);
    chk(hint_o == 1, "R10 hint follows bit 1", hint_o, 1);
    host(0, 2'd2, 0, rd, cyc);
    chk(port_cycles == pc, "R3 hint write does not unlock", port_cycles, pc);

    // control register width and unlock
    host(1, 2'd1, 32'hFFFF_FFFF, rd, cyc);
    host(0, 2'd1, 0, rd, cyc);
    chk(rd == 32'h3 && cyc == 1, "R2 control readback", rd, 32'h3);
    chk(port_cycles == pc, "R2 control no port", port_cycles, pc);
    host(1, 2'd1, 32'h0000_0001, rd, cyc);
    chk(hint_o == 0, "R10 hint cleared", hint_o, 0);

    // reserved select
    host(1, 2'd3, 32'hFFFF_FFFF, rd, cyc);
    host(0, 2'd3, 0, rd, cyc);
    chk(rd == 0 && port_cycles == pc, "R11 reserved read 0 no port", rd, 0);
    host(0, 2'd1, 0, rd, cyc);
    chk(rd == 32'h1, "R11 reserved write no effect", rd, 32'h1);

    // sweep: order x ready delay x operation
    for (int ord = 1; ord >= 0; ord--) begin
      host(1, 2'd1, {30'd0, 1'b0, ord[0]}, rd, cyc);
      for (int w = 0; w < 3; w++) begin
        wait_n = w;
        for (int op = 0; op < 3; op++) begin
          logic        we;
          logic [1:0]  sel;
          logic [31:0] wd;
          we  = (op != 2);
          sel = (op == 0) ? 2'd0 : 2'd2;
          wd  = {16'hA000 + 16'(ord * 64 + w * 8 + op), 16'h0500 + 16'(w * 16 + op)};
          rd_pat[0] = 16'h3C00 + 16'(w * 4 + op);
          rd_pat[1] = 16'hC300 + 16'(ord * 32 + w);
          host(we, sel, wd, rd, cyc);
          chk(lg_n == 2, "R7 two transfers per access", lg_n, 2);
          chk(cyc >= 3 + 2 * w, "R7 ack after both ready", cyc, 3 + 2 * w);
          chk(lg_half[0] == 0 && lg_half[1] == 1, "R6 half select order",
              {lg_half[0], lg_half[1]}, 2'b01);
          chk(lg_reg[0] == (sel == 2'd2) && lg_reg[1] == (sel == 2'd2),
              (sel == 2'd2) ? "R9 data register code" : "R8 address register code",
              lg_reg[0], (sel == 2'd2));
          chk(lg_we[0] == we && lg_we[1] == we, "R9 port direction", lg_we[0], we);
          if (we) begin
            first  = ord ? wd[15:0] : wd[31:16];
            second = ord ? wd[31:16] : wd[15:0];
            chk(lg_data[0] == first && lg_data[1] == second, "R5 write halfword order",
                {lg_data[0], lg_data[1]}, {first, second});
          end else begin
            exp_rd = ord ? {rd_pat[1], rd_pat[0]} : {rd_pat[0], rd_pat[1]};
            chk(rd == exp_rd, "R5 read assembly", rd, exp_rd);
          end
          if (op == 0) begin
            pc = port_cycles;
            host(0, 2'd0, 0, rd, cyc);
            chk(rd == wd && port_cycles == pc, "R8 address readback local", rd, wd);
          end
        end
      end
      if (ord == 0) chk(1, "R4 order 0 still unlocked", 0, 0);
    end
    chk(hint_o == 0, "R10 hint unchanged by data", hint_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule